// File: doc/BRIEF.md
# I2C Master Command Queue Engine

This block sequences an I2C master from a queue of command words. Software pushes words into a transmit command FIFO. Each word carries a data byte, a read flag and a stop flag. The engine opens the bus with a START and sends the address byte. It then performs one byte write or one byte read per word. Received bytes go into a receive FIFO that the host pops.

When two queued words in a row go in opposite directions, the engine changes direction by itself. With restart enabled it inserts a repeated START followed by a fresh address byte; with restart disabled it closes the bus with a STOP and opens it again. A STOP follows any byte whose stop flag is set. If the queue runs dry while the bus is owned, the engine waits with the clock held low.

Bit-level SCL/SDA timing belongs to a separate timing block. This engine hands that block one operation at a time (START, repeated START, byte write, byte read, STOP) through a request/done handshake. It also keeps a small set of sticky interrupt flags and a status word.

Top module: `i2cq_engine`

## Requirements
- R1: A command word holds the write data in bits [7:0], the read flag in bit 8 (1 = read one byte, data bits ignored) and the stop flag in bit 9. A STOP operation is issued right after the byte of any word whose stop flag is set.
- R2: When the bus is not owned, the first queued word causes a START operation and then an address byte written as {address[6:0], direction}, where direction 1 means read. The data operation comes after these.
- R3: When consecutive words change direction on an owned bus, the engine issues a repeated START plus a new address byte if restartEn is 1. If restartEn is 0, it issues STOP, START and the address byte instead.
- R4: A read operation requests a NACK from the master (opNack = 1) exactly when its word's stop flag is set. Each received byte is pushed into the receive FIFO in arrival order and is visible on rxData.
- R5: If the command FIFO is empty while the bus is owned and no STOP is pending, no operation is requested and master activity (status bit 5) stays 1.
- R6: A NACK on an address or write byte sets raw interrupt bit 6 (transmit abort), flushes the command FIFO and issues a STOP.
- R7: Raw interrupt bit 9 sets when a STOP operation completes. A clrStopDet pulse clears only bit 9. A clrAll pulse clears all sticky bits (0, 1, 3, 6, 9). A set in the same cycle wins over a clear.
- R8: Writing to a full command FIFO drops the word and sets bit 3. Pushing a received byte into a full receive FIFO drops it and sets bit 1. Popping an empty receive FIFO sets bit 0 and rxData reads 0. Bit 4 is the level "command FIFO empty".
- R9: Status bits: 0 activity (master activity, or enabled with queued commands), 1 command FIFO not full, 2 command FIFO empty, 3 receive FIFO not empty, 4 receive FIFO full, 5 master activity (an operation in flight, the bus owned, or a STOP pending).
- R10: targetAddr is sampled when the engine becomes enabled. Dropping enable closes an owned bus with a STOP, flushes the command FIFO, and only then lowers enableStatus. No operation is requested while enableStatus is 0.
- R11: Operation codes on opKind are 1 START, 2 repeated START, 3 byte write, 4 byte read and 5 STOP. opReq stays high, with opKind and opByte unchanged, until the cycle in which opDone is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Enable request |
| restartEn | input | 1 | Allow repeated START on direction change |
| targetAddr | input | 7 | Target address, sampled at enable |
| cmdWrite | input | 1 | Push cmdWord into the command FIFO |
| cmdWord | input | 10 | Command word {stop, read, data} |
| rxRead | input | 1 | Pop the receive FIFO |
| rxData | output | 8 | Head of the receive FIFO (0 when empty) |
| clrStopDet | input | 1 | Clear stop-detect interrupt bit |
| clrAll | input | 1 | Clear all sticky interrupt bits |
| status | output | 6 | Status word |
| rawIntr | output | 10 | Raw interrupt flags |
| enableStatus | output | 1 | Engine actually enabled |
| opReq | output | 1 | Operation request to the timing block |
| opKind | output | 3 | Operation code |
| opByte | output | 8 | Byte to send for a write operation |
| opNack | output | 1 | Master NACK for a read operation |
| opDone | input | 1 | Timing block finished the operation |
| opNackIn | input | 1 | Target NACKed the written byte (valid with opDone) |
| opRdByte | input | 8 | Byte received by a read (valid with opDone) |

## Verification
The assertions assume the timing block obeys the handshake: it raises opDone only while opReq is high, for a single cycle, and opNackIn means something only when a byte write completes. The bench's timing model answers each request after 0 to 2 idle cycles with a one-cycle done pulse. It NACKs only when a test asks for it. Commands are queued while the engine is disabled, or while it holds the bus, so the expected operation sequence does not depend on push timing.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
  localparam int ADDR_W   = 7;
  localparam int DATA_W   = 8;
  localparam int CMD_W    = DATA_W + 2;
  localparam int CMD_RD   = 8;
  localparam int CMD_STOP = 9;
  localparam int STAT_W   = 6;
  localparam int INTR_W   = 10;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_START   = 3'd1,
    OP_RESTART = 3'd2,
    OP_WRITE   = 3'd3,
    OP_READ    = 3'd4,
    OP_STOP    = 3'd5
  } opKind_e;

  typedef struct packed {
    logic txPop;
    logic txFlush;
    logic rxPush;
    logic setAbort;
    logic setStopDet;
  } ctrlStrobe_t;
endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full
);
  // DEPTH must be a power of two so the pointers wrap on their own.
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [AW:0]      count;
  logic             doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == (AW+1)'(DEPTH));
  assign doPush = push && !full && !flush;
  assign doPop  = pop && !empty && !flush;
  assign rdata  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      count <= count + (AW+1)'(doPush) - (AW+1)'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wdata;
  end
endmodule

// File: rtl/i2cq_datapath.sv
module i2cq_datapath
  import i2cq_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrite,
  input  logic [CMD_W-1:0]  cmdWord,
  input  logic              rxRead,
  output logic [DATA_W-1:0] rxData,
  input  logic              clrStopDet,
  input  logic              clrAll,
  input  logic [DATA_W-1:0] rxByteIn,
  input  ctrlStrobe_t       strobe,
  input  logic              masterAct,
  input  logic              enabledNow,
  output logic [CMD_W-1:0]  txHead,
  output logic              txEmpty,
  output logic [STAT_W-1:0] status,
  output logic [INTR_W-1:0] rawIntr
);
  logic              txFull, rxEmpty, rxFull;
  logic [DATA_W-1:0] rxHead;
  logic              rxUnder, rxOver, txOver, txAbort, stopDet;

  i2cq_fifo #(.WIDTH(CMD_W), .DEPTH(TX_DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN), .push(cmdWrite), .pop(strobe.txPop),
    .flush(strobe.txFlush), .wdata(cmdWord), .rdata(txHead),
    .empty(txEmpty), .full(txFull)
  );

  i2cq_fifo #(.WIDTH(DATA_W), .DEPTH(RX_DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN), .push(strobe.rxPush), .pop(rxRead),
    .flush(1'b0), .wdata(rxByteIn), .rdata(rxHead),
    .empty(rxEmpty), .full(rxFull)
  );

  assign rxData = rxEmpty ? '0 : rxHead;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxUnder <= 1'b0;
      rxOver  <= 1'b0;
      txOver  <= 1'b0;
      txAbort <= 1'b0;
      stopDet <= 1'b0;
    end else begin
      rxUnder <= (rxUnder && !clrAll) || (rxRead && rxEmpty);
      rxOver  <= (rxOver  && !clrAll) || (strobe.rxPush && rxFull);
      txOver  <= (txOver  && !clrAll) || (cmdWrite && txFull);
      txAbort <= (txAbort && !clrAll) || strobe.setAbort;
      stopDet <= (stopDet && !clrAll && !clrStopDet) || strobe.setStopDet;
    end
  end

  assign rawIntr = {stopDet, 2'b00, txAbort, 1'b0, txEmpty, txOver, 1'b0, rxOver, rxUnder};
  assign status  = {masterAct, rxFull, !rxEmpty, txEmpty, !txFull,
                    masterAct || (enabledNow && !txEmpty)};
endmodule

// File: rtl/i2cq_ctrl.sv
module i2cq_ctrl
  import i2cq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              restartEn,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic [CMD_W-1:0]  txHead,
  input  logic              txEmpty,
  input  logic              opDone,
  input  logic              opNackIn,
  output logic              opReq,
  output logic [2:0]        opKind,
  output logic [DATA_W-1:0] opByte,
  output logic              opNack,
  output ctrlStrobe_t       strobe,
  output logic              masterAct,
  output logic              enableStatus
);
  typedef enum logic {S_IDLE, S_BUSY} state_e;

  state_e            state;
  opKind_e           kindQ, nKind;
  logic [DATA_W-1:0] byteQ, nByte;
  logic              nackQ, nNack, isAddrQ, nIsAddr, nPop, issue;
  logic              lastStopQ, active, curDir, needAddr, pendStop, enStat;
  logic [ADDR_W-1:0] addrQ;
  logic              finish, abortDone, disFlush;

  // Choose the next bus operation while idle.
  always_comb begin
    issue   = 1'b0;
    nKind   = OP_NONE;
    nByte   = '0;
    nNack   = 1'b0;
    nIsAddr = 1'b0;
    nPop    = 1'b0;
    if (state == S_IDLE && enStat) begin
      if (pendStop || (!enable && active)) begin
        issue = 1'b1;
        nKind = OP_STOP;
      end else if (enable) begin
        if (needAddr) begin
          issue   = 1'b1;
          nKind   = OP_WRITE;
          nByte   = {addrQ, curDir};
          nIsAddr = 1'b1;
        end else if (!txEmpty) begin
          issue = 1'b1;
          if (!active) begin
            nKind = OP_START;
          end else if (txHead[CMD_RD] != curDir) begin
            nKind = restartEn ? OP_RESTART : OP_STOP;
          end else begin
            nPop  = 1'b1;
            nKind = txHead[CMD_RD] ? OP_READ : OP_WRITE;
            nByte = txHead[CMD_RD] ? '0 : txHead[DATA_W-1:0];
            nNack = txHead[CMD_RD] && txHead[CMD_STOP];
          end
        end
      end
    end
  end

  assign finish    = (state == S_BUSY) && opDone;
  assign abortDone = finish && (kindQ == OP_WRITE) && opNackIn;
  assign disFlush  = enStat && !enable && (state == S_IDLE) && !active && !pendStop;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      kindQ     <= OP_NONE;
      byteQ     <= '0;
      nackQ     <= 1'b0;
      isAddrQ   <= 1'b0;
      lastStopQ <= 1'b0;
      active    <= 1'b0;
      curDir    <= 1'b0;
      needAddr  <= 1'b0;
      pendStop  <= 1'b0;
      enStat    <= 1'b0;
      addrQ     <= '0;
    end else begin
      if (!enStat && enable) begin
        enStat <= 1'b1;
        addrQ  <= targetAddr;
      end else if (disFlush) begin
        enStat <= 1'b0;
      end

      if (issue) begin
        state   <= S_BUSY;
        kindQ   <= nKind;
        byteQ   <= nByte;
        nackQ   <= nNack;
        isAddrQ <= nIsAddr;
        if (nPop) lastStopQ <= txHead[CMD_STOP];
        if (nKind == OP_START || nKind == OP_RESTART) curDir <= txHead[CMD_RD];
      end

      if (finish) begin
        state <= S_IDLE;
        unique case (kindQ)
          OP_START, OP_RESTART: begin
            active   <= 1'b1;
            needAddr <= 1'b1;
          end
          OP_WRITE: begin
            if (isAddrQ) needAddr <= 1'b0;
            if (opNackIn || (!isAddrQ && lastStopQ)) pendStop <= 1'b1;
          end
          OP_READ: begin
            if (lastStopQ) pendStop <= 1'b1;
          end
          OP_STOP: begin
            active   <= 1'b0;
            pendStop <= 1'b0;
            needAddr <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign opReq        = (state == S_BUSY);
  assign opKind       = kindQ;
  assign opByte       = byteQ;
  assign opNack       = nackQ;
  assign masterAct    = (state == S_BUSY) || active || pendStop;
  assign enableStatus = enStat;

  assign strobe.txPop      = nPop;
  assign strobe.txFlush    = abortDone || disFlush;
  assign strobe.rxPush     = finish && (kindQ == OP_READ);
  assign strobe.setAbort   = abortDone;
  assign strobe.setStopDet = finish && (kindQ == OP_STOP);
endmodule

// File: rtl/i2cq_engine.sv
module i2cq_engine
  import i2cq_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        restartEn,
  input  logic [6:0]  targetAddr,
  input  logic        cmdWrite,
  input  logic [9:0]  cmdWord,
  input  logic        rxRead,
  output logic [7:0]  rxData,
  input  logic        clrStopDet,
  input  logic        clrAll,
  output logic [5:0]  status,
  output logic [9:0]  rawIntr,
  output logic        enableStatus,
  output logic        opReq,
  output logic [2:0]  opKind,
  output logic [7:0]  opByte,
  output logic        opNack,
  input  logic        opDone,
  input  logic        opNackIn,
  input  logic [7:0]  opRdByte
);
  ctrlStrobe_t       strobe;
  logic [CMD_W-1:0]  txHead;
  logic              txEmpty, masterAct;

  i2cq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .restartEn(restartEn),
    .targetAddr(targetAddr), .txHead(txHead), .txEmpty(txEmpty),
    .opDone(opDone), .opNackIn(opNackIn), .opReq(opReq), .opKind(opKind),
    .opByte(opByte), .opNack(opNack), .strobe(strobe),
    .masterAct(masterAct), .enableStatus(enableStatus)
  );

  i2cq_datapath #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite), .cmdWord(cmdWord),
    .rxRead(rxRead), .rxData(rxData), .clrStopDet(clrStopDet),
    .clrAll(clrAll), .rxByteIn(opRdByte), .strobe(strobe),
    .masterAct(masterAct), .enabledNow(enableStatus), .txHead(txHead),
    .txEmpty(txEmpty), .status(status), .rawIntr(rawIntr)
  );
endmodule

// File: rtl/i2cq_engine_chk.sv
module i2cq_engine_chk (
  input logic       clk,
  input logic       rstN,
  input logic       enableStatus,
  input logic       opReq,
  input logic [2:0] opKind,
  input logic [7:0] opByte,
  input logic       opDone,
  input logic       opNackIn,
  input logic       masterActive,
  input logic       txEmptyFlag,
  input logic       abortFlag,
  input logic       stopFlag
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    opReq && !opDone |=> opReq && $stable(opKind) && $stable(opByte)); // R11
  AST_STOP_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    opReq && opDone && opKind == 3'd5 |=> stopFlag); // R7
  AST_NACK_ABORTS: assert property (@(posedge clk) disable iff (!rstN)
    opReq && opDone && opNackIn && opKind == 3'd3 |=> abortFlag && txEmptyFlag); // R6
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !enableStatus |-> !opReq); // R10
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !masterActive |-> !opReq); // R9
endmodule

bind i2cq_engine i2cq_engine_chk u_chk (
  .clk(clk), .rstN(rstN), .enableStatus(enableStatus), .opReq(opReq),
  .opKind(opKind), .opByte(opByte), .opDone(opDone), .opNackIn(opNackIn),
  .masterActive(status[5]), .txEmptyFlag(status[2]),
  .abortFlag(rawIntr[6]), .stopFlag(rawIntr[9])
);

// File: tb/i2cq_engine_bench.sv
module i2cq_engine_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0, restartEn = 1'b1;
  logic [6:0] targetAddr = '0;
  logic       cmdWrite = 1'b0;
  logic [9:0] cmdWord = '0;
  logic       rxRead = 1'b0, clrStopDet = 1'b0, clrAll = 1'b0;
  logic [7:0] rxData;
  logic [5:0] status;
  logic [9:0] rawIntr;
  logic       enableStatus, opReq, opNack;
  logic [2:0] opKind;
  logic [7:0] opByte;
  logic       opDone = 1'b0, opNackIn = 1'b0;
  logic [7:0] opRdByte = '0;

  int checks = 0, errors = 0;

  i2cq_engine u_i2cq_engine (.*);

  always #4 clk = ~clk;

  // Timing-block model: log every operation, answer after 0..2 cycles.
  logic [11:0] opLog [512];
  int          logCount = 0;
  int          rdCnt = 0;
  logic        nackAddr = 1'b0;
  logic        afterStart = 1'b0;

  function automatic logic [7:0] rdVal(input int i);
    return 8'h3C + 8'(i * 29);
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      opDone   = 1'b0;
      opNackIn = 1'b0;
      if (opReq) begin
        if (logCount < 512) opLog[logCount] = {opKind, opByte, opNack};
        logCount++;
        repeat ($urandom % 3) @(negedge clk);
        opDone = 1'b1;
        if (opKind == 3'd1 || opKind == 3'd2) afterStart = 1'b1;
        if (opKind == 3'd3) begin
          opNackIn   = afterStart && nackAddr;
          afterStart = 1'b0;
        end
        if (opKind == 3'd4) begin
          opRdByte = rdVal(rdCnt);
          rdCnt++;
        end
      end
    end
  end

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Command list and expected-operation model.
  logic [9:0]  cmdArr [8];
  logic [11:0] expOp [40];
  logic [7:0]  expRd [8];
  logic [7:0]  saveRd [8];
  int          expCnt, expRdCnt;

  task automatic addExp(input logic [2:0] k, input logic [7:0] b, input logic n);
    expOp[expCnt] = {k, b, n};
    expCnt++;
  endtask

  task automatic buildExp(input int n, input logic rs, input logic [6:0] addr, input int rb);
    logic act = 1'b0, dir = 1'b0;
    expCnt = 0;
    expRdCnt = 0;
    for (int i = 0; i < n; i++) begin
      logic rd = cmdArr[i][8];
      if (act && rd != dir) begin
        if (rs) begin
          addExp(3'd2, 8'h00, 1'b0);
          addExp(3'd3, {addr, rd}, 1'b0);
        end else begin
          addExp(3'd5, 8'h00, 1'b0);
          act = 1'b0;
        end
      end
      if (!act) begin
        addExp(3'd1, 8'h00, 1'b0);
        addExp(3'd3, {addr, rd}, 1'b0);
        act = 1'b1;
      end
      dir = rd;
      if (rd) begin
        addExp(3'd4, 8'h00, cmdArr[i][9]);
        expRd[expRdCnt] = rdVal(rb + expRdCnt);
        expRdCnt++;
      end else begin
        addExp(3'd3, cmdArr[i][7:0], 1'b0);
      end
      if (cmdArr[i][9]) begin
        addExp(3'd5, 8'h00, 1'b0);
        act = 1'b0;
      end
    end
  endtask

  task automatic pushCmd(input logic [9:0] w);
    cmdWrite = 1'b1;
    cmdWord  = w;
    @(negedge clk);
    cmdWrite = 1'b0;
  endtask

  task automatic pulseRx();
    rxRead = 1'b1;
    @(negedge clk);
    rxRead = 1'b0;
  endtask

  task automatic waitIdle();
    repeat (3) @(negedge clk);
    for (int k = 0; k < 3000; k++) begin
      if (!status[5] && status[2]) break;
      @(negedge clk);
    end
  endtask

  task automatic compareLog(input int base, input string tag);
    chk({tag, " op count"}, logCount - base, expCnt);
    for (int i = 0; i < expCnt; i++) chk({tag, " op entry"}, opLog[base + i], expOp[i]);
  endtask

  task automatic runSeq(input int n, input logic rs, input logic [6:0] addr,
                        input logic keepRx, input logic ovf);
    int base = logCount;
    int rb   = rdCnt;
    restartEn  = rs;
    targetAddr = addr;
    for (int i = 0; i < n; i++) pushCmd(cmdArr[i]);
    if (ovf) begin
      pushCmd(10'h2FF);
      chk("R8 tx overflow flag", rawIntr[3], 1'b1);
      chk("R9 status with full queue, disabled", status, 6'b000000);
    end
    enable = 1'b1;
    waitIdle();
    buildExp(n, rs, addr, rb);
    compareLog(base, "R1 R2 R3");
    if (!keepRx) begin
      for (int i = 0; i < expRdCnt; i++) begin
        chk("R4 rx byte", rxData, expRd[i]);
        pulseRx();
      end
    end
    chk("R7 stop detect set", rawIntr[9], 1'b1);
    clrStopDet = 1'b1;
    @(negedge clk);
    clrStopDet = 1'b0;
    chk("R7 stop detect cleared", rawIntr[9], 1'b0);
    enable = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 enable status low", enableStatus, 1'b0);
  endtask

  initial begin
    int seedInit = $urandom(32'h5EED);
    int base;
    if (seedInit == -1) $display("seed");
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Reset state
    chk("R9 reset status", status, 6'b000110);
    chk("R8 reset interrupts", rawIntr, 10'h010);
    chk("R10 reset enable status", enableStatus, 1'b0);
    chk("R11 reset no request", opReq, 1'b0);

    // Directed: write, direction change with restart, read with stop
    cmdArr[0] = 10'h0A5; cmdArr[1] = 10'h15A; cmdArr[2] = 10'h300;
    runSeq(3, 1'b1, 7'h2A, 1'b0, 1'b0);
    // Same commands without restart: STOP/START on direction change (R3)
    cmdArr[0] = 10'h0A5; cmdArr[1] = 10'h100; cmdArr[2] = 10'h300;
    runSeq(3, 1'b0, 7'h51, 1'b0, 1'b0);

    // Random sequences, last word always carries a stop
    for (int it = 0; it < 8; it++) begin
      int n = 1 + ($urandom % 8);
      for (int i = 0; i < n; i++) begin
        logic st = (($urandom % 5) == 0) || (i == n - 1);
        cmdArr[i] = {st, 1'($urandom % 2), 8'($urandom)};
      end
      runSeq(n, 1'($urandom % 2), 7'($urandom), 1'b0, 1'b0);
    end

    // R8: command overflow drops the extra word
    for (int i = 0; i < 8; i++) cmdArr[i] = {(i == 7), 1'b0, 8'h10 + 8'(i)};
    runSeq(8, 1'b1, 7'h11, 1'b0, 1'b1);
    clrAll = 1'b1;
    @(negedge clk);
    clrAll = 1'b0;
    chk("R7 clear all", rawIntr, 10'h010);

    // R4/R8/R9: fill receive FIFO, overflow, underflow
    for (int i = 0; i < 8; i++) cmdArr[i] = {(i == 7), 1'b1, 8'h00};
    runSeq(8, 1'b1, 7'h33, 1'b1, 1'b0);
    for (int i = 0; i < 8; i++) saveRd[i] = expRd[i];
    chk("R9 rx full and not empty", status[4:3], 2'b11);
    cmdArr[0] = 10'h300;
    runSeq(1, 1'b1, 7'h33, 1'b1, 1'b0);
    chk("R8 rx overflow flag", rawIntr[1], 1'b1);
    for (int i = 0; i < 8; i++) begin
      chk("R4 rx byte after fill", rxData, saveRd[i]);
      pulseRx();
    end
    chk("R8 rx empty reads zero", rxData, 8'h00);
    pulseRx();
    chk("R8 rx underflow flag", rawIntr[0], 1'b1);
    clrAll = 1'b1;
    @(negedge clk);
    clrAll = 1'b0;

    // R5 hold, R10 address sampled at enable
    base = logCount;
    restartEn = 1'b1;
    targetAddr = 7'h21;
    pushCmd(10'h011);
    enable = 1'b1;
    repeat (40) @(negedge clk);
    chk("R5 held, master active", status[5], 1'b1);
    chk("R5 held, no request", opReq, 1'b0);
    chk("R5 held, op count", logCount - base, 3);
    targetAddr = 7'h55;
    pushCmd(10'h222);
    pushCmd(10'h233);
    waitIdle();
    cmdArr[0] = 10'h011; cmdArr[1] = 10'h222; cmdArr[2] = 10'h233;
    buildExp(3, 1'b1, 7'h21, 0);
    compareLog(base, "R10 sampled address");
    enable = 1'b0;
    repeat (4) @(negedge clk);

    // R10: disable while the bus is owned
    base = logCount;
    clrAll = 1'b1;
    @(negedge clk);
    clrAll = 1'b0;
    targetAddr = 7'h30;
    pushCmd(10'h044);
    enable = 1'b1;
    repeat (40) @(negedge clk);
    enable = 1'b0;
    repeat (40) @(negedge clk);
    chk("R10 disable closes bus, op count", logCount - base, 4);
    chk("R10 disable issues stop", opLog[base + 3], {3'd5, 8'h00, 1'b0});
    chk("R10 enable status dropped", enableStatus, 1'b0);
    chk("R7 stop detect after disable", rawIntr[9], 1'b1);

    // R6: address NACK aborts
    base = logCount;
    nackAddr = 1'b1;
    cmdArr[0] = 10'h001; cmdArr[1] = 10'h202; cmdArr[2] = 10'h300;
    restartEn = 1'b1;
    targetAddr = 7'h7E;
    for (int i = 0; i < 3; i++) pushCmd(cmdArr[i]);
    enable = 1'b1;
    waitIdle();
    chk("R6 abort op count", logCount - base, 3);
    chk("R6 abort stop", opLog[base + 2], {3'd5, 8'h00, 1'b0});
    chk("R6 abort flag", rawIntr[6], 1'b1);
    chk("R6 command queue flushed", status[2], 1'b1);
    nackAddr = 1'b0;
    clrAll = 1'b1;
    @(negedge clk);
    clrAll = 1'b0;
    chk("R7 clear all after abort", rawIntr, 10'h010);
    enable = 1'b0;
    repeat (4) @(negedge clk);

    finishRun();
  end
endmodule